// File: doc/BRIEF.md
# Block-Based TDM Channel Slot Selector

This block sits beside a serial framer and decides, slot by slot, whether the word occupying the current time slot of a time-division frame is moved or skipped. A frame carries up to 128 channel slots, split into eight blocks of 16 consecutive channels. The block keeps its own channel index: a frame-sync strobe restarts it at channel 0, and each word-done strobe from the serializer moves it one slot forward. A skipped slot still takes up its place in time; only the transfer is suppressed.

At most two blocks can be live at once. One of them is an even-numbered block, picked by a 2-bit selector and enabled bit-by-bit from the lower 16 bits of a 32-bit enable word; the other is an odd-numbered block, picked by a second 2-bit selector and enabled from the upper 16 bits. The enable word and both selectors are taken in only at block boundaries, so software can rewrite them while a block is running and the new pattern applies from the next block. A single interrupt line pulses for one of four event kinds, chosen by a 2-bit mode input; the end-of-block kind gives software the moment to reprogram.

Top module: `tdm_slot_selector`

## Requirements
- R1: A cycle with `frame_sync_i` high sets `chan_idx_o` to 0 on that clock edge, even if `word_done_i` is high in the same cycle.
- R2: A cycle with `word_done_i` high and `frame_sync_i` low advances `chan_idx_o` by one on that edge; from 127 it wraps to 0. With neither strobe high the index holds.
- R3: When the current block number (`chan_idx_o[6:4]`) is even and its upper two bits (`chan_idx_o[6:5]`) equal the latched even-block selector, `slot_en_o` equals bit `chan_idx_o[3:0]` of the latched enable word (1 = transfer).
- R4: When the current block number is odd and `chan_idx_o[6:5]` equals the latched odd-block selector, `slot_en_o` equals bit `16 + chan_idx_o[3:0]` of the latched enable word.
- R5: In any block matching neither latched selector, `slot_en_o` is 0 regardless of the enable word.
- R6: The enable word and both selectors are latched only on a `frame_sync_i` cycle or on a `word_done_i` cycle at channel offset 15 of a block; changes at other times do not alter `slot_en_o` until that boundary.
- R7: With `int_mode_i` = 2'b00, `irq_o` pulses for a `word_done_i` cycle whose slot had `slot_en_o` = 1, and not for one whose slot was disabled.
- R8: With `int_mode_i` = 2'b01, `irq_o` pulses for a `word_done_i` cycle at channel offset 15 (end of block).
- R9: With `int_mode_i` = 2'b10, `irq_o` pulses for every `frame_sync_i` cycle and not for `word_done_i`.
- R10: With `int_mode_i` = 2'b11, `irq_o` pulses for a `frame_sync_i` cycle that arrives while `chan_idx_o` is not 0 (premature sync); a sync at index 0 raises nothing.
- R11: `irq_o` is registered: it is high for exactly the one cycle after the edge that sampled its event. After reset the index, `slot_en_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | Start-of-frame strobe |
| word_done_i | input | 1 | Strobe at the end of each word slot |
| en_mask_i | input | 32 | Channel enables: [15:0] even block, [31:16] odd block |
| blk_even_sel_i | input | 2 | Picks even block 2*n |
| blk_odd_sel_i | input | 2 | Picks odd block 2*n+1 |
| int_mode_i | input | 2 | Interrupt source select |
| chan_idx_o | output | 7 | Current channel slot in the frame |
| slot_en_o | output | 1 | Current slot is transferred |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The index and the latched enables update on the edge that samples a strobe, and `slot_en_o` is decoded combinationally from them, so both are due immediately after that edge; `irq_o` passes through one register and is likewise due right after the edge that sampled its event, then low one cycle later. The bench applies each strobe for exactly one clock, reads outputs a nanosecond after the edge that consumed it, and for the pulse checks it again after one idle clock. Boundary-latching is checked by changing the enable word mid-block and reading the slot before and after the 16th word.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  typedef enum logic [1:0] {
    IRQ_WORD     = 2'b00,
    IRQ_EOB      = 2'b01,
    IRQ_FRAME    = 2'b10,
    IRQ_SYNC_ERR = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/tdm_chan_counter.sv
module tdm_chan_counter #(
  parameter int NUM_CHANS = 128,
  parameter int BLK_CHANS = 16,
  localparam int CHAN_W = $clog2(NUM_CHANS),
  localparam int SLOT_W = $clog2(BLK_CHANS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  input  logic              word_done_i,
  output logic [CHAN_W-1:0] idx_o,
  output logic              blk_last_o
);
  localparam logic [CHAN_W-1:0] LastIdx = CHAN_W'(NUM_CHANS - 1);
  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(BLK_CHANS - 1);

  logic [CHAN_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idx_q <= '0;
    else if (frame_sync_i)  idx_q <= '0;
    else if (word_done_i)   idx_q <= (idx_q == LastIdx) ? '0 : idx_q + 1'b1;
  end

  assign idx_o      = idx_q;
  assign blk_last_o = (idx_q[SLOT_W-1:0] == LastSlot);
endmodule

// File: rtl/tdm_enable_bank.sv
module tdm_enable_bank #(
  parameter int NUM_CHANS = 128,
  parameter int BLK_CHANS = 16,
  localparam int CHAN_W = $clog2(NUM_CHANS),
  localparam int SLOT_W = $clog2(BLK_CHANS),
  localparam int BSEL_W = CHAN_W - SLOT_W - 1,
  localparam int MASK_W = 2 * BLK_CHANS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [BSEL_W-1:0] even_sel_i,
  input  logic [BSEL_W-1:0] odd_sel_i,
  input  logic [CHAN_W-1:0] idx_i,
  output logic              slot_en_o
);
  logic [MASK_W-1:0] mask_q;
  logic [BSEL_W-1:0] sel_q [2];
  logic [1:0]        half_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      sel_q[0] <= '0;
      sel_q[1] <= '0;
    end else if (load_i) begin
      mask_q   <= mask_i;
      sel_q[0] <= even_sel_i;
      sel_q[1] <= odd_sel_i;
    end
  end

  logic [SLOT_W-1:0] slot;
  logic [BSEL_W-1:0] pair;
  logic              odd_blk;

  assign slot    = idx_i[SLOT_W-1:0];
  assign odd_blk = idx_i[SLOT_W];
  assign pair    = idx_i[CHAN_W-1:SLOT_W+1];

  // half 0 serves even blocks, half 1 odd blocks
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [BLK_CHANS-1:0] bits;
    assign bits        = mask_q[h*BLK_CHANS +: BLK_CHANS];
    assign half_hit[h] = (odd_blk == h[0]) && (pair == sel_q[h]) && bits[slot];
  end

  assign slot_en_o = |half_hit;
endmodule

// File: rtl/tdm_irq_gen.sv
module tdm_irq_gen
  import tdm_slot_pkg::*;
#(
  parameter int CHAN_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  irq_mode_e         mode_i,
  input  logic              frame_sync_i,
  input  logic              word_done_i,
  input  logic              slot_en_i,
  input  logic              blk_last_i,
  input  logic [CHAN_W-1:0] idx_i,
  output logic              irq_o
);
  logic evt;
  logic irq_q;

  always_comb begin
    unique case (mode_i)
      IRQ_WORD:     evt = word_done_i & slot_en_i;
      IRQ_EOB:      evt = word_done_i & blk_last_i;
      IRQ_FRAME:    evt = frame_sync_i;
      IRQ_SYNC_ERR: evt = frame_sync_i & (idx_i != '0);
      default:      evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= evt;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tdm_slot_selector.sv
module tdm_slot_selector
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CHANS = 128,
  parameter int BLK_CHANS = 16,
  localparam int CHAN_W = $clog2(NUM_CHANS),
  localparam int SLOT_W = $clog2(BLK_CHANS),
  localparam int BSEL_W = CHAN_W - SLOT_W - 1,
  localparam int MASK_W = 2 * BLK_CHANS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_sync_i,
  input  logic              word_done_i,
  input  logic [MASK_W-1:0] en_mask_i,
  input  logic [BSEL_W-1:0] blk_even_sel_i,
  input  logic [BSEL_W-1:0] blk_odd_sel_i,
  input  logic [1:0]        int_mode_i,
  output logic [CHAN_W-1:0] chan_idx_o,
  output logic              slot_en_o,
  output logic              irq_o
);
  logic blk_last;
  logic load;

  tdm_chan_counter #(.NUM_CHANS(NUM_CHANS), .BLK_CHANS(BLK_CHANS)) u_cnt (
    .clk_i, .rst_ni,
    .frame_sync_i, .word_done_i,
    .idx_o      (chan_idx_o),
    .blk_last_o (blk_last)
  );

  // reload only where a new block starts
  assign load = frame_sync_i | (word_done_i & blk_last);

  tdm_enable_bank #(.NUM_CHANS(NUM_CHANS), .BLK_CHANS(BLK_CHANS)) u_en (
    .clk_i, .rst_ni,
    .load_i     (load),
    .mask_i     (en_mask_i),
    .even_sel_i (blk_even_sel_i),
    .odd_sel_i  (blk_odd_sel_i),
    .idx_i      (chan_idx_o),
    .slot_en_o
  );

  tdm_irq_gen #(.CHAN_W(CHAN_W)) u_irq (
    .clk_i, .rst_ni,
    .mode_i       (irq_mode_e'(int_mode_i)),
    .frame_sync_i, .word_done_i,
    .slot_en_i    (slot_en_o),
    .blk_last_i   (blk_last),
    .idx_i        (chan_idx_o),
    .irq_o
  );
endmodule

// File: rtl/tdm_slot_selector_chk.sv
module tdm_slot_selector_chk #(
  parameter int CHAN_W = 7,
  parameter int SLOT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_sync_i,
  input logic              word_done_i,
  input logic [1:0]        int_mode_i,
  input logic [CHAN_W-1:0] chan_idx_o,
  input logic              slot_en_o,
  input logic              irq_o
);
  a_r1_sync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> chan_idx_o == '0);

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && !frame_sync_i) |=> chan_idx_o == CHAN_W'($past(chan_idx_o) + 1'b1));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_done_i && !frame_sync_i) |=> $stable(chan_idx_o));

  a_r6_no_mid_block_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_done_i && !frame_sync_i) |=> $stable(slot_en_o));

  a_r8_eob_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i == 2'b01 && word_done_i && (&chan_idx_o[SLOT_W-1:0])) |=> irq_o);

  a_r9_frame_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i == 2'b10 && frame_sync_i) |=> irq_o);

  a_r11_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_done_i && !frame_sync_i) |=> !irq_o);
endmodule

bind tdm_slot_selector tdm_slot_selector_chk #(.CHAN_W(CHAN_W), .SLOT_W(SLOT_W)) u_chk (
  .clk_i, .rst_ni, .frame_sync_i, .word_done_i, .int_mode_i,
  .chan_idx_o, .slot_en_o, .irq_o
);

// File: tb/tdm_slot_selector_tb.sv
module tdm_slot_selector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        wd = 1'b0;
  logic [31:0] mask = '0;
  logic [1:0]  esel = '0;
  logic [1:0]  osel = '0;
  logic [1:0]  mode = '0;
  logic [6:0]  idx;
  logic        en;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tdm_slot_selector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_sync_i(fs), .word_done_i(wd),
    .en_mask_i(mask), .blk_even_sel_i(esel), .blk_odd_sel_i(osel),
    .int_mode_i(mode), .chan_idx_o(idx), .slot_en_o(en), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] m;
    logic [1:0]  e;
    logic [1:0]  o;
    logic [6:0]  ch;
    logic        x;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{32'h0000_0001, 2'd0, 2'd0, 7'd0,   1'b1},  // R3
    '{32'h0000_0001, 2'd0, 2'd0, 7'd1,   1'b0},  // R3
    '{32'h8000_0000, 2'd0, 2'd0, 7'd31,  1'b1},  // R4
    '{32'h0000_FFFF, 2'd1, 2'd0, 7'd37,  1'b1},  // R3
    '{32'h0000_FFFF, 2'd1, 2'd0, 7'd5,   1'b0},  // R5
    '{32'h0004_0000, 2'd0, 2'd3, 7'd114, 1'b1},  // R4
    '{32'h0004_0000, 2'd0, 2'd2, 7'd114, 1'b0},  // R5
    '{32'hFFFF_FFFF, 2'd3, 2'd3, 7'd105, 1'b1},  // R3
    '{32'hFFFF_FFFF, 2'd3, 2'd3, 7'd80,  1'b0}   // R5
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic w);
    fs = f;
    wd = w;
    @(posedge clk);
    #1;
    fs = 1'b0;
    wd = 1'b0;
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    #25;
    // R11 reset state
    chk("R11 idx", int'(idx), 0);
    chk("R11 en", int'(en), 0);
    chk("R11 irq", int'(irq), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // table walk
    for (int v = 0; v < 9; v++) begin
      mask = VEC[v].m;
      esel = VEC[v].e;
      osel = VEC[v].o;
      step(1'b1, 1'b0);
      words(int'(VEC[v].ch));
      chk("R2 idx", int'(idx), int'(VEC[v].ch));
      chk("R3/R4/R5 en", int'(en), int'(VEC[v].x));
    end

    // R6 boundary latching, R9 frame irq
    mode = 2'b10;
    mask = 32'hFFFF_FFFF; esel = 2'd0; osel = 2'd0;
    step(1'b1, 1'b0);
    chk("R9 irq on sync", int'(irq), 1);
    step(1'b0, 1'b0);
    chk("R11 pulse ends", int'(irq), 0);
    words(3);
    chk("R9 no irq on word", int'(irq), 0);
    mask = 32'h0;
    step(1'b0, 1'b0);
    chk("R6 mid-block en", int'(en), 1);
    words(12);
    chk("R6 idx15 en", int'(en), 1);
    words(1);
    chk("R6 idx", int'(idx), 16);
    chk("R6 new mask at boundary", int'(en), 0);

    // R1 priority
    step(1'b1, 1'b1);
    chk("R1 sync wins", int'(idx), 0);

    // R10 sync error
    mode = 2'b11;
    step(1'b1, 1'b0);
    chk("R10 sync at 0", int'(irq), 0);
    words(5);
    step(1'b1, 1'b0);
    chk("R10 early sync", int'(irq), 1);
    chk("R1 idx", int'(idx), 0);

    // R8 end of block
    mode = 2'b01;
    mask = 32'hFFFF_FFFF;
    step(1'b1, 1'b0);
    words(15);
    chk("R8 no irq at 14", int'(irq), 0);
    words(1);
    chk("R8 irq at eob", int'(irq), 1);
    step(1'b0, 1'b0);
    chk("R11 eob pulse ends", int'(irq), 0);

    // R7 word ready
    mode = 2'b00;
    mask = 32'h0000_0002; esel = 2'd0;
    step(1'b1, 1'b0);
    words(1);
    chk("R7 disabled slot", int'(irq), 0);
    words(1);
    chk("R7 enabled slot", int'(irq), 1);

    // R2 wrap
    step(1'b1, 1'b0);
    words(127);
    chk("R2 idx 127", int'(idx), 127);
    words(1);
    chk("R2 wrap", int'(idx), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule